// File: doc/BRIEF.md
# Port-Width Transfer Splitter with Burst Option

This block sits between a 32-bit bus master and an external port that may be 8, 16 or 32 bits wide. It accepts one master transfer at a time (a byte, a word, a longword or a 16-byte cache line) and turns it into a sequence of port-sized beats. For each beat it drives the beat address, the beat size, the write data on the low lanes of the port data bus, and a start strobe. When the transfer is finished it returns a single completion pulse to the master. For reads, it also returns the assembled data.

The port width and two burst enables arrive with each access from the chip-select control. One enable covers writes and the other covers reads. When a transfer is wider than the port and the enable for its direction is set, the beats form a single burst: the burst flag stays high from the first beat to the last, and there is one start strobe. When the enable is clear, every beat is an independent, non-burst access with its own start strobe. A transfer no wider than the port always goes out as a single non-burst beat. Wait states are set by the port, which acknowledges each beat whenever it is ready.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `p_active`, `p_start`, `p_burst` and `m_done` are low.
- R2: A transfer no wider than the port is issued as exactly one beat with `p_burst` low, whatever the two burst enables are. Size codes: 0 byte, 1 word, 2 longword, 3 line. Port codes: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit.
- R3: With `burst_wr_en`=0, a write wider than the port is issued as separate port-sized beats. Each beat has `p_burst` low and its own one-cycle `p_start` in its first cycle. For example, a longword to an 8-bit port gives four byte beats.
- R4: With `burst_wr_en`=1, a write wider than the port is issued as one burst. `p_burst` is high from the first beat until the last beat's acknowledge, and `p_start` pulses only in the first cycle of the first beat.
- R5: A line transfer takes 16, 8 or 4 beats on an 8-, 16- or 32-bit port. It follows the burst rule of R3/R4, including on a 32-bit port.
- R6: Reads follow the same splitting and burst rules, controlled by `burst_rd_en`. `burst_wr_en` has no effect on reads and `burst_rd_en` has no effect on writes.
- R7: Beat addresses start at `m_addr` and rise by the beat size in bytes. `p_size` gives the beat size (0 byte, 1 word, 2 longword). Write data is big-endian: the master value is right-aligned in `m_wdata`, its most significant byte goes out first, and each beat's bytes sit right-aligned on `p_wdata`. `m_wdata` bits above the transfer size are ignored.
- R8: Read beats return data right-aligned on `p_rdata`. The first beat forms the most significant part. `m_rdata` holds the whole transfer right-aligned while `m_done` is high.
- R9: `m_done` is a single-cycle pulse in the cycle after the last beat's `p_ack` is sampled.
- R10: A `m_req` raised while a transfer is in progress is ignored. Neither the beats in flight nor any later beat reflect it.
- R11: A `p_ack` seen while no beat is active is ignored. It creates no `m_done`, and it does not shorten the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request; taken when idle |
| m_write | input | 1 | 1 = write, 0 = read |
| m_size | input | 2 | Transfer size code |
| m_addr | input | ADDR_W | Transfer start address |
| m_wdata | input | LINE_BYTES*8 | Write data, right-aligned |
| port_sel | input | 2 | Port width code |
| burst_wr_en | input | 1 | Burst enable for writes |
| burst_rd_en | input | 1 | Burst enable for reads |
| m_done | output | 1 | Completion pulse |
| m_rdata | output | LINE_BYTES*8 | Assembled read data, right-aligned |
| p_active | output | 1 | A beat is outstanding |
| p_start | output | 1 | Access start strobe |
| p_burst | output | 1 | Burst in progress |
| p_last | output | 1 | Current beat is the final one |
| p_write | output | 1 | Direction of the current beat |
| p_size | output | 2 | Beat size code |
| p_addr | output | ADDR_W | Beat address |
| p_wdata | output | 32 | Beat write data, right-aligned |
| p_ack | input | 1 | Port acknowledge, ends the current beat |
| p_rdata | input | 32 | Beat read data, right-aligned |

## Verification
The hardest situations to reach from the ports are a master request, or a stray acknowledge, that lands while the splitter is in a state where it should not react. The bench raises `m_req` with a different address and size in the middle of a multi-beat read, and then checks every later beat address and the single completion. It also pulses `p_ack` several times while idle, and then runs a full multi-beat transfer to show that no beat was consumed early. A vector table covers every pairing of size, port width and burst enable that changes the beat count or the burst flag. In that table, the slave answers some beats at once and holds off others by two cycles, so both zero-wait and waited beats are checked.

// File: rtl/xs_pkg.sv
package xs_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BEAT = 1'b1
   } xs_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;
   localparam logic [1:0] SZ_LINE = 2'd3;

   localparam logic [1:0] PW_8  = 2'd0;
   localparam logic [1:0] PW_16 = 2'd1;

   // log2 of the port width in bytes; code 3 is treated as 32-bit
   function automatic logic [1:0] port_lg(input logic [1:0] code);
      case (code)
         PW_8:    port_lg = 2'd0;
         PW_16:   port_lg = 2'd1;
         default: port_lg = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/xs_beat_plan.sv
module xs_beat_plan
   import xs_pkg::*;
#(
   parameter int LINE_LG = 4,
   parameter int LG_W    = 3,
   parameter int CNT_W   = 5
)(
   input  logic [1:0]       size,
   input  logic [1:0]       port,
   input  logic             write,
   input  logic             bwe,
   input  logic             bre,
   output logic [LG_W-1:0]  xfer_lg,
   output logic [1:0]       beat_lg,
   output logic [CNT_W-1:0] nbeats_m1,
   output logic             burst
);
   logic [1:0]      plg;
   logic [LG_W-1:0] nb_lg;
   logic            dir_en;

   always_comb begin
      case (size)
         SZ_BYTE: xfer_lg = LG_W'(0);
         SZ_WORD: xfer_lg = LG_W'(1);
         SZ_LONG: xfer_lg = LG_W'(2);
         default: xfer_lg = LG_W'(LINE_LG);
      endcase
      plg = port_lg(port);
      // beat size is the smaller of transfer and port
      if (xfer_lg < LG_W'(plg)) beat_lg = xfer_lg[1:0];
      else                      beat_lg = plg;
      nb_lg     = xfer_lg - LG_W'(beat_lg);
      nbeats_m1 = (CNT_W'(1) << nb_lg) - CNT_W'(1);
      dir_en    = write ? bwe : bre;
      burst     = (nb_lg != '0) && dir_en;
   end

endmodule

// File: rtl/xs_seq.sv
module xs_seq
   import xs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_write,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [CNT_W-1:0]  plan_nbm1,
   input  logic [1:0]        plan_blg,
   input  logic              plan_burst,
   input  logic              p_ack,
   output logic              accept,
   output logic              advance,
   output logic [1:0]        blg,
   output logic              busy,
   output logic              p_start,
   output logic              p_burst,
   output logic              p_last,
   output logic              p_write,
   output logic [ADDR_W-1:0] p_addr,
   output logic              m_done
);
   xs_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q, last_q;
   logic [ADDR_W-1:0] addr_q;
   logic              burst_q, wr_q, spend_q, done_q;
   logic [1:0]        blg_q;
   logic              at_last;

   assign busy    = (state_q == ST_BEAT);
   assign accept  = m_req && !busy;
   assign advance = busy && p_ack;
   assign at_last = (cnt_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         last_q  <= '0;
         addr_q  <= '0;
         burst_q <= 1'b0;
         wr_q    <= 1'b0;
         spend_q <= 1'b0;
         done_q  <= 1'b0;
         blg_q   <= 2'd0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_BEAT;
            cnt_q   <= '0;
            last_q  <= plan_nbm1;
            addr_q  <= m_addr;
            burst_q <= plan_burst;
            wr_q    <= m_write;
            blg_q   <= plan_blg;
            spend_q <= 1'b1;
         end else if (busy) begin
            spend_q <= 1'b0;
            if (advance) begin
               if (at_last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q   <= cnt_q + CNT_W'(1);
                  addr_q  <= addr_q + (ADDR_W'(1) << blg_q);
                  spend_q <= !burst_q;
               end
            end
         end
      end
   end

   assign blg     = blg_q;
   assign p_start = busy && spend_q;
   assign p_burst = busy && burst_q;
   assign p_last  = busy && at_last;
   assign p_write = busy && wr_q;
   assign p_addr  = addr_q;
   assign m_done  = done_q;

endmodule

// File: rtl/xs_wshift.sv
module xs_wshift #(
   parameter int LINE_W = 128,
   parameter int LG_W   = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [LINE_W-1:0] wdata,
   input  logic [LG_W-1:0]   xfer_lg,
   input  logic [1:0]        blg,
   output logic [31:0]       lane_out
);
   localparam int SH_W = $clog2(LINE_W) + 1;

   logic [LINE_W-1:0] buf_q;
   logic [SH_W-1:0]   load_sh, beat_sh;
   logic [31:0]       lane [3];

   assign load_sh = SH_W'(LINE_W) - (SH_W'(8) << xfer_lg);
   assign beat_sh = SH_W'(8) << blg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q <= '0;
      else if (load)    buf_q <= wdata << load_sh;
      else if (advance) buf_q <= buf_q << beat_sh;
   end

   // one candidate lane image per beat width
   for (genvar g = 0; g < 3; g++) begin : g_lane
      localparam int BW = 8 << g;
      assign lane[g] = 32'(buf_q[LINE_W-1 -: BW]);
   end

   always_comb begin
      case (blg)
         2'd0:    lane_out = lane[0];
         2'd1:    lane_out = lane[1];
         default: lane_out = lane[2];
      endcase
   end

endmodule

// File: rtl/xs_rasm.sv
module xs_rasm #(
   parameter int LINE_W = 128
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic [1:0]        blg,
   input  logic [31:0]       rdata,
   output logic [LINE_W-1:0] asm_out
);
   localparam int SH_W = $clog2(LINE_W) + 1;

   logic [LINE_W-1:0] buf_q;
   logic [31:0]       mask;
   logic [SH_W-1:0]   beat_sh;

   assign beat_sh = SH_W'(8) << blg;

   always_comb begin
      case (blg)
         2'd0:    mask = 32'h0000_00FF;
         2'd1:    mask = 32'h0000_FFFF;
         default: mask = 32'hFFFF_FFFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q <= '0;
      else if (clear)   buf_q <= '0;
      else if (capture) buf_q <= (buf_q << beat_sh) | LINE_W'(rdata & mask);
   end

   assign asm_out = buf_q;

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
   import xs_pkg::*;
#(
   parameter  int ADDR_W     = 32,
   parameter  int LINE_BYTES = 16,
   localparam int LINE_W     = LINE_BYTES * 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_write,
   input  logic [1:0]        m_size,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [LINE_W-1:0] m_wdata,
   input  logic [1:0]        port_sel,
   input  logic              burst_wr_en,
   input  logic              burst_rd_en,
   output logic              m_done,
   output logic [LINE_W-1:0] m_rdata,
   output logic              p_active,
   output logic              p_start,
   output logic              p_burst,
   output logic              p_last,
   output logic              p_write,
   output logic [1:0]        p_size,
   output logic [ADDR_W-1:0] p_addr,
   output logic [31:0]       p_wdata,
   input  logic              p_ack,
   input  logic [31:0]       p_rdata
);
   localparam int LINE_LG = $clog2(LINE_BYTES);
   localparam int LG_W    = $clog2(LINE_LG + 1);
   localparam int CNT_W   = LINE_LG + 1;

   if (LINE_BYTES < 4 || (1 << LINE_LG) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (ADDR_W < LINE_LG + 1) begin : g_bad_addr
      $error("ADDR_W too small for a line");
   end

   logic [LG_W-1:0]  xfer_lg;
   logic [1:0]       plan_blg, blg;
   logic [CNT_W-1:0] plan_nbm1;
   logic             plan_burst, accept, advance, busy;

   xs_beat_plan #(.LINE_LG(LINE_LG), .LG_W(LG_W), .CNT_W(CNT_W)) u_plan (
      .size      (m_size),
      .port      (port_sel),
      .write     (m_write),
      .bwe       (burst_wr_en),
      .bre       (burst_rd_en),
      .xfer_lg   (xfer_lg),
      .beat_lg   (plan_blg),
      .nbeats_m1 (plan_nbm1),
      .burst     (plan_burst)
   );

   xs_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .m_req      (m_req),
      .m_write    (m_write),
      .m_addr     (m_addr),
      .plan_nbm1  (plan_nbm1),
      .plan_blg   (plan_blg),
      .plan_burst (plan_burst),
      .p_ack      (p_ack),
      .accept     (accept),
      .advance    (advance),
      .blg        (blg),
      .busy       (busy),
      .p_start    (p_start),
      .p_burst    (p_burst),
      .p_last     (p_last),
      .p_write    (p_write),
      .p_addr     (p_addr),
      .m_done     (m_done)
   );

   xs_wshift #(.LINE_W(LINE_W), .LG_W(LG_W)) u_wsh (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .advance  (advance),
      .wdata    (m_wdata),
      .xfer_lg  (xfer_lg),
      .blg      (blg),
      .lane_out (p_wdata)
   );

   xs_rasm #(.LINE_W(LINE_W)) u_rasm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .capture (advance && !p_write),
      .blg     (blg),
      .rdata   (p_rdata),
      .asm_out (m_rdata)
   );

   assign p_active = busy;
   assign p_size   = blg;

endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
   parameter int ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              m_done,
   input logic              p_active,
   input logic              p_start,
   input logic              p_burst,
   input logic              p_last,
   input logic [1:0]        p_size,
   input logic [ADDR_W-1:0] p_addr,
   input logic              p_ack
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !p_active |-> (!p_start && !p_burst)); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      m_done |=> !m_done); // R9
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      m_done |-> $past(p_active && p_last && p_ack)); // R9
   AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (p_active && p_burst && !(p_last && p_ack)) |=> (p_active && p_burst)); // R4
   AST_BURST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (p_active && p_burst && !(p_last && p_ack)) |=> !p_start); // R4
   AST_SINGLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (p_active && !p_burst && p_ack && !p_last) |=> p_start); // R3
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (p_active && p_ack && !p_last) |=>
         (p_addr == $past(p_addr) + (ADDR_W'(1) << $past(p_size)))); // R7
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (p_active && !p_ack) |=> ($stable(p_addr) && $stable(p_size))); // R7
   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_active && p_ack && !m_done) |=> !m_done); // R11
endmodule

bind xfer_splitter xs_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .m_done   (m_done),
   .p_active (p_active),
   .p_start  (p_start),
   .p_burst  (p_burst),
   .p_last   (p_last),
   .p_size   (p_size),
   .p_addr   (p_addr),
   .p_ack    (p_ack)
);

// File: tb/tb_xfer_splitter.sv
module tb_xfer_splitter;
   localparam int LW = 128;
   localparam int NV = 16;

   // {write, size, port, bwe, bre, nbeats, burst}
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 5'd4,  1'b0},
      {1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 5'd4,  1'b1},
      {1'b1, 2'd2, 2'd1, 1'b1, 1'b0, 5'd2,  1'b1},
      {1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 5'd2,  1'b1},
      {1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 5'd2,  1'b0},
      {1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 5'd1,  1'b0},
      {1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 5'd1,  1'b0},
      {1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 5'd16, 1'b1},
      {1'b1, 2'd3, 2'd1, 1'b0, 1'b1, 5'd8,  1'b0},
      {1'b1, 2'd3, 2'd2, 1'b1, 1'b0, 5'd4,  1'b1},
      {1'b1, 2'd3, 2'd2, 1'b0, 1'b1, 5'd4,  1'b0},
      {1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 5'd4,  1'b1},
      {1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 5'd2,  1'b0},
      {1'b0, 2'd3, 2'd1, 1'b0, 1'b1, 5'd8,  1'b1},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 5'd1,  1'b0},
      {1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 5'd16, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          m_req = 1'b0, m_write = 1'b0;
   logic [1:0]    m_size = '0, port_sel = '0;
   logic [31:0]   m_addr = '0;
   logic [LW-1:0] m_wdata = '0;
   logic          burst_wr_en = 1'b0, burst_rd_en = 1'b0;
   logic          m_done, p_active, p_start, p_burst, p_last, p_write;
   logic [LW-1:0] m_rdata;
   logic [1:0]    p_size;
   logic [31:0]   p_addr, p_wdata;
   logic          p_ack = 1'b0;
   logic [31:0]   p_rdata = '0;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10ns clk = ~clk;

   xfer_splitter dut (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_write(m_write),
      .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata),
      .port_sel(port_sel), .burst_wr_en(burst_wr_en), .burst_rd_en(burst_rd_en),
      .m_done(m_done), .m_rdata(m_rdata), .p_active(p_active),
      .p_start(p_start), .p_burst(p_burst), .p_last(p_last),
      .p_write(p_write), .p_size(p_size), .p_addr(p_addr),
      .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] sbyte(input logic [31:0] a);
      return a[7:0] ^ 8'h5A ^ a[15:8];
   endfunction

   // Run one transfer; inject=1 raises a stray request mid-transfer
   task automatic run_xfer(input bit wr, input logic [1:0] sz, input logic [1:0] pt,
                           input bit bwe, input bit bre, input logic [31:0] base,
                           input logic [LW-1:0] wd, input int nb, input bit bst,
                           input string tag, input bit inject);
      int xb = (sz == 2'd3) ? 16 : (1 << sz);
      int pb = 1 << ((pt == 2'd0) ? 0 : (pt == 2'd1) ? 1 : 2);
      int bb = (xb < pb) ? xb : pb;
      logic [LW-1:0] exp_rd = '0;
      @(negedge clk);
      m_req = 1'b1; m_write = wr; m_size = sz; port_sel = pt;
      burst_wr_en = bwe; burst_rd_en = bre; m_addr = base; m_wdata = wd;
      @(negedge clk);
      m_req = 1'b0;
      for (int k = 0; k < nb; k++) begin
         logic [31:0] ea = base + 32'(k * bb);
         logic [31:0] ew = '0, rv = '0;
         for (int b = 0; b < bb; b++) begin
            ew = (ew << 8) | 32'(wd[(xb - 1 - (k * bb + b)) * 8 +: 8]);
            rv = (rv << 8) | 32'(sbyte(ea + 32'(b)));
         end
         chk(p_active, tag, "beat active", LW'(p_active), 1);
         chk(p_start == (k == 0 || !bst), tag, "start strobe", LW'(p_start), LW'(k == 0 || !bst));
         chk(p_burst == bst, tag, "burst flag", LW'(p_burst), LW'(bst));
         chk(p_last == (k == nb - 1), tag, "last flag", LW'(p_last), LW'(k == nb - 1));
         chk(p_addr == ea, "R7", "beat address", LW'(p_addr), LW'(ea));
         chk(p_size == 2'($clog2(bb)), "R7", "beat size", LW'(p_size), LW'($clog2(bb)));
         if (wr) chk(p_wdata == ew, "R7", "beat write data", LW'(p_wdata), LW'(ew));
         p_rdata = rv;
         if (k % 3 == 1) begin
            for (int w = 0; w < 2; w++) begin
               if (inject && k == 1 && w == 0) begin
                  m_req = 1'b1; m_addr = 32'h0009_0000; m_size = 2'd0;
               end
               @(negedge clk);
               m_req = 1'b0;
               chk(!p_start && p_active, tag, "wait cycle strobe", LW'(p_start), 0);
               chk(p_addr == ea, inject ? "R10" : "R7", "held address", LW'(p_addr), LW'(ea));
            end
         end
         p_ack = 1'b1;
         @(negedge clk);
         p_ack = 1'b0;
         chk(m_done == (k == nb - 1), "R9", "done timing", LW'(m_done), LW'(k == nb - 1));
      end
      for (int o = 0; o < xb; o++) exp_rd = (exp_rd << 8) | LW'(sbyte(base + 32'(o)));
      if (!wr) chk(m_rdata == exp_rd, "R8", "assembled read", m_rdata, exp_rd);
      chk(!p_active, inject ? "R10" : tag, "idle after last", LW'(p_active), 0);
      @(negedge clk);
      chk(!m_done, "R9", "done is one pulse", LW'(m_done), 0);
      chk(!p_active, inject ? "R10" : "R1", "stays idle", LW'(p_active), 0);
      for (int g = 0; g < 40 && p_active; g++) begin
         p_ack = 1'b1; @(negedge clk); p_ack = 1'b0;
      end
   endtask

   function automatic string vec_tag(input logic [12:0] v);
      if (v[5:1] == 5'd1) return "R2";
      if (v[11:10] == 2'd3) return "R5";
      if (!v[12]) return "R6";
      return v[0] ? "R4" : "R3";
   endfunction

   initial begin
      #(20ns * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!p_active && !p_start && !p_burst && !m_done, "R1", "reset state",
          LW'({p_active, p_start, p_burst, m_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!p_active && !m_done, "R1", "idle after reset", LW'({p_active, m_done}), 0);

      for (int i = 0; i < NV; i++) begin
         logic [LW-1:0] wd;
         for (int j = 0; j < 16; j++) wd[j * 8 +: 8] = 8'(8'hA0 + j * 7 + i);
         run_xfer(VEC[i][12], VEC[i][11:10], VEC[i][9:8], VEC[i][7], VEC[i][6],
                  32'h0040_0000 + 32'(i) * 32'h100, wd, int'(VEC[i][5:1]), VEC[i][0],
                  vec_tag(VEC[i]), 1'b0);
      end

      // R10: stray request during a non-burst longword read on an 8-bit port
      run_xfer(1'b0, 2'd2, 2'd0, 1'b1, 1'b0, 32'h0050_0000, '0, 4, 1'b0, "R10", 1'b1);

      // R11: acknowledges while idle, then a full line burst must still take 8 beats
      for (int a = 0; a < 3; a++) begin
         @(negedge clk); p_ack = 1'b1;
         @(negedge clk); p_ack = 1'b0;
         chk(!m_done && !p_active, "R11", "ack while idle", LW'({m_done, p_active}), 0);
      end
      run_xfer(1'b1, 2'd3, 2'd1, 1'b1, 1'b0, 32'h0060_0000, {16{8'h3C}}, 8, 1'b1, "R11", 1'b0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule